// File: doc/BRIEF.md
# ECC Result Readout Buffer

This block sits between a flash page parity engine and a CPU. The engine produces two 24-bit parity codes for each page. It hands each code over with a one-cycle strobe. The block keeps the six resulting bytes and returns them one at a time through a single byte-wide register. Each CPU read of that register returns the next byte.

A CPU write to the register restarts everything. The value written does not matter. The write clears the stored bytes, the fill position and the read position, and it sends a one-cycle clear pulse to the parity engine. After both codes have landed, the block produces a one-cycle ready pulse. The engine raises this pulse the same way whether spare-area bytes are handled automatically or by software, so the block has no mode input.

Top module: `ecc_readout_buf`

## Requirements
- R1: After the asynchronous reset, `rd_data_o` is 0x00, and `ready_o` and `eng_clr_o` are low.
- R2: The first `code_valid_i` strobe after a clear stores `code_i` into bytes 0..2, as bits [7:0], [15:8] and [23:16]. The second strobe stores into bytes 3..5 in the same way.
- R3: Successive reads return byte 0 through byte 5 in order: low, middle and high byte of the first code, then low, middle and high byte of the second code.
- R4: The data of a read appears on `rd_data_o` in the cycle after `rd_i`. It holds until the next read or write.
- R5: The read after byte 5 returns byte 0, because the read position wraps.
- R6: A write (`wr_i`), whatever the value of `wr_data_i`, clears all six bytes, the fill position and the read position. It also drives `rd_data_o` to 0x00.
- R7: `eng_clr_o` is high for exactly the one cycle after each write.
- R8: `ready_o` is a one-cycle pulse in the cycle after the strobe that fills bytes 3..5.
- R9: Strobes that arrive after both codes are stored are ignored. They change no byte and produce no ready pulse.
- R10: A write takes priority over a read or a strobe in the same cycle. The read returns 0x00 and does not advance. The strobe is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| code_valid_i | input | 1 | Parity code strobe from the engine |
| code_i | input | 24 | Parity code value |
| rd_i | input | 1 | CPU read of the register |
| wr_i | input | 1 | CPU write of the register |
| wr_data_i | input | 8 | Write data (ignored) |
| rd_data_o | output | 8 | Register read data |
| ready_o | output | 1 | Both codes stored (pulse) |
| eng_clr_o | output | 1 | Clear pulse to the parity engine |

## Verification
Two situations are hard to reach from the ports. The first is a collision in a single cycle: a write together with a read, or a write together with a code strobe. The second is a strobe that arrives after the buffer is already full.

The bench drives these collisions on purpose in every pass of its sweep. After each one it exposes the hidden state through the normal interface. A strobe that follows a dropped one must land in bytes 0..2 without a ready pulse. A read that follows an extra strobe must still return the earlier codes.

// File: rtl/ecc_rb_pkg.sv
package ecc_rb_pkg;
  localparam int unsigned BYTE_W_DEF = 8;
  localparam int unsigned CODE_BYTES_DEF = 3;
  localparam int unsigned NUM_CODES_DEF = 2;
endpackage

// File: rtl/ecc_rb_store.sv
module ecc_rb_store #(
  parameter int unsigned BW = 8,
  parameter int unsigned CB = 3,
  parameter int unsigned NC = 2,
  localparam int unsigned NB = CB * NC,
  localparam int unsigned FW = $clog2(NC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CB*BW-1:0] code_i,
  output logic [NB*BW-1:0] bytes_o,
  output logic             ready_o
);
  logic [FW-1:0] fill_q;
  logic          take;

  // write has priority; strobes beyond the last code are dropped
  assign take = load_i && !clr_i && (fill_q < FW'(NC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q  <= '0;
      ready_o <= 1'b0;
    end else if (clr_i) begin
      fill_q  <= '0;
      ready_o <= 1'b0;
    end else begin
      if (take) fill_q <= fill_q + FW'(1);
      ready_o <= take && (fill_q == FW'(NC - 1));
    end
  end

  for (genvar c = 0; c < NC; c++) begin : g_code
    for (genvar b = 0; b < CB; b++) begin : g_byte
      logic [BW-1:0] byte_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                         byte_q <= '0;
        else if (clr_i)                      byte_q <= '0;
        else if (take && fill_q == FW'(c))   byte_q <= code_i[b*BW +: BW];
      end
      assign bytes_o[(c*CB+b)*BW +: BW] = byte_q;
    end
  end

  a_r8_ready_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  a_r8_ready_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> $past(load_i) && !$past(clr_i));
  a_r9_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_q <= FW'(NC));
  a_r9_full_static: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == FW'(NC)) && !clr_i |=> $stable(bytes_o) && !ready_o);
endmodule

// File: rtl/ecc_rb_rdseq.sv
module ecc_rb_rdseq #(
  parameter int unsigned BW = 8,
  parameter int unsigned NB = 6,
  localparam int unsigned PW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             rd_i,
  input  logic [NB*BW-1:0] bytes_i,
  output logic [BW-1:0]    rd_data_o
);
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] ptr_nxt;

  assign ptr_nxt = (ptr_q == PW'(NB - 1)) ? '0 : ptr_q + PW'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      rd_data_o <= '0;
    end else if (clr_i) begin
      ptr_q     <= '0;
      rd_data_o <= '0;
    end else if (rd_i) begin
      ptr_q     <= ptr_nxt;
      rd_data_o <= bytes_i[ptr_q*BW +: BW];
    end
  end

  a_r5_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q < PW'(NB));
  a_r10_clr_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (rd_data_o == '0) && (ptr_q == '0));
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i && !clr_i |=> $stable(rd_data_o) && $stable(ptr_q));
endmodule

// File: rtl/ecc_readout_buf.sv
module ecc_readout_buf
  import ecc_rb_pkg::*;
#(
  parameter int unsigned BYTE_W = BYTE_W_DEF,
  parameter int unsigned CODE_BYTES = CODE_BYTES_DEF,
  parameter int unsigned NUM_CODES = NUM_CODES_DEF,
  localparam int unsigned CODE_W = BYTE_W * CODE_BYTES,
  localparam int unsigned NBYTES = CODE_BYTES * NUM_CODES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              code_valid_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              ready_o,
  output logic              eng_clr_o
);
  logic [NBYTES*BYTE_W-1:0] bytes;
  logic                     unused_wr_data;

  assign unused_wr_data = ^wr_data_i;

  ecc_rb_store #(.BW(BYTE_W), .CB(CODE_BYTES), .NC(NUM_CODES)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr_i),
    .load_i  (code_valid_i),
    .code_i  (code_i),
    .bytes_o (bytes),
    .ready_o (ready_o)
  );

  ecc_rb_rdseq #(.BW(BYTE_W), .NB(NBYTES)) u_rdseq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (wr_i),
    .rd_i      (rd_i),
    .bytes_i   (bytes),
    .rd_data_o (rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) eng_clr_o <= 1'b0;
    else         eng_clr_o <= wr_i;
  end

  a_r7_clr_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> eng_clr_o);
  a_r7_clr_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_clr_o |-> $past(wr_i));
  a_r10_no_ready_after_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !ready_o);
endmodule

// File: tb/ecc_readout_buf_test.sv
module ecc_readout_buf_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        code_valid = 1'b0;
  logic [23:0] code = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [7:0]  rd_data;
  logic        ready;
  logic        eng_clr;

  int n_vec = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  ecc_readout_buf uut (
    .clk_i(clk), .rst_ni(rst_n), .code_valid_i(code_valid), .code_i(code),
    .rd_i(rd), .wr_i(wr), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .ready_o(ready), .eng_clr_o(eng_clr)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    code_valid = 0; rd = 0; wr = 0;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [23:0] ca, cb, cx;
    logic [7:0]  exp_b [6];
    #12;
    chk("R1 rd_data", 32'(rd_data), 0);
    chk("R1 ready", 32'(ready), 0);
    chk("R1 eng_clr", 32'(eng_clr), 0);
    rst_n = 1;
    step();
    chk("R1 after release", 32'(rd_data), 0);

    for (int k = 0; k < 12; k++) begin
      ca = {8'(k*37+5), 8'(k*11+2), 8'(k*29+1)};
      cb = {8'(k*53+9), 8'(k*19+7), 8'(k*3+250)};
      cx = ~ca;
      for (int i = 0; i < 3; i++) begin
        exp_b[i]   = ca[i*8 +: 8];
        exp_b[i+3] = cb[i*8 +: 8];
      end
      // R6: write with arbitrary data clears everything
      idle(); wr = 1; wr_data = 8'(k*91);
      step(); idle();
      chk("R7 eng_clr after write", 32'(eng_clr), 1);
      chk("R6 rd_data zero", 32'(rd_data), 0);
      rd = 1; step(); idle();
      chk("R6 cleared byte0", 32'(rd_data), 0);
      chk("R7 eng_clr single", 32'(eng_clr), 0);
      wr = 1; step(); idle();                 // rewind pointer
      // R2/R8: load two codes
      code_valid = 1; code = ca; step();
      chk("R8 no ready after first", 32'(ready), 0);
      code = cb; step(); idle();
      chk("R8 ready after second", 32'(ready), 1);
      step();
      chk("R8 ready single cycle", 32'(ready), 0);
      // R9: extra strobe ignored
      code_valid = 1; code = cx; step(); idle();
      chk("R9 no ready on extra", 32'(ready), 0);
      // R2/R3/R5: sequential reads with wrap
      for (int i = 0; i < 8 + (k % 5); i++) begin
        rd = 1; step(); idle();
        chk((i >= 6) ? "R5 wrap read" : "R3 R2 ordered read",
            32'(rd_data), 32'(exp_b[i % 6]));
        if (i == 3) begin
          step(); step();
          chk("R4 hold without read", 32'(rd_data), 32'(exp_b[3]));
        end
      end
      // R10: read with write in same cycle
      rd = 1; wr = 1; step(); idle();
      chk("R10 read+write zero", 32'(rd_data), 0);
      rd = 1; step(); idle();
      chk("R10 pointer at 0, bytes cleared", 32'(rd_data), 0);
      // R10: strobe with write dropped
      wr = 1; code_valid = 1; code = cb; step(); idle();
      code_valid = 1; code = ca; step(); idle();
      chk("R10 dropped strobe no ready", 32'(ready), 0);
      for (int i = 0; i < 4; i++) begin
        rd = 1; step(); idle();
        chk("R10 strobe landed in first slot", 32'(rd_data),
            (i < 3) ? 32'(ca[i*8 +: 8]) : 0);
      end
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule